// File: doc/BRIEF.md
# Seven-Channel Block DMA Engine with Completion Flags

The block is a memory-mapped DMA engine. It has up to seven channels. Each channel owns a 16-byte window in a register zone. The window holds a start address, a word that splits into block size and block count, and a control word. A shared priority register and an interrupt flag register follow the channel windows. Software sets a channel's run bit by writing its control word. The engine then reads memory one 32-bit word at a time and hands each word to a peripheral over a valid/ready stream, tagged with the channel number.

The engine works on one channel at a time and moves one whole block before it chooses again. When several channels are running, the lowest-numbered one gets the next block. After each block the channel's block count drops by one. When the count reaches zero, the run bit clears and the channel's completion flag is set. The interrupt output stays high while any completion flag is set. Software acknowledges a flag by writing a one to it.

Top module: `dmac_top`

## Requirements
- R1: Channel n owns zone offsets 16·n to 16·n+15, with the channel index equal to offset bits [7:4]. The start address register sits at window offset 0x0, the block word at 0x4 and the control word at 0x8. Each reads back what was last written to it.
- R2: In the block word, bits [15:0] hold the block size in 32-bit words and bits [31:16] hold the block count. A 16-bit write (`bus_half`=1) at window offset 0x6 replaces only the count with `bus_wdata[15:0]`. A full-width write at 0x6 has no effect.
- R3: Only control bits 0, 9, 10 and 24 (run) are stored. Every other control bit reads back as zero.
- R4: A control write with bit 24 set starts the channel. The engine streams (block size × block count) words, fetched from ascending byte addresses that begin at the start address modulo 2^29 and step by 4. Each word goes out on `st_data` with `st_chan` equal to the channel index.
- R5: A word on the stream stays valid with stable data and channel until `st_ready` is seen. The engine issues one memory read per word, and the data returns one cycle after `mem_rd_en`.
- R6: The start address register advances by 4 for each word, wrapping inside its low 29 bits and keeping bits [31:29]. The block count drops by one per finished block. When it reaches zero, run (bit 24) clears and flag bit 24+n of the flag register is set.
- R7: Starting with a block count of zero ends the transfer at once, with no words, and sets the flag. A block size of zero uses up blocks without moving any word.
- R8: A write to the flag register stores bits [23:0] as written. It clears each bit of [31:24] where the written value is 1 and keeps it where the value is 0.
- R9: The priority register is plain read/write storage at zone offset 0x70. The flag register is at 0x74.
- R10: Reads of any other offset (window offsets 0x4 + 2, 0xC and above, zone offsets 0x78 and up) return zero. Full writes there change nothing.
- R11: While a channel's run bit is set, writes to its address, block and control registers are ignored.
- R12: `irq` is high exactly while at least one completion flag in bits [30:24] is set.
- R13: After reset every register reads zero, and `irq`, `st_valid` and `mem_rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_half | input | 1 | Write is 16 bits wide (count half at offset 0x6) |
| bus_addr | input | 8 | Zone byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | MEM_AW | Memory byte address |
| mem_rdata | input | 32 | Memory data, one cycle after the request |
| st_valid | output | 1 | Stream word valid |
| st_data | output | 32 | Stream word |
| st_chan | output | 3 | Channel that owns the stream word |
| st_ready | input | 1 | Peripheral accepts the word |
| irq | output | 1 | Any completion flag set |

## Verification
The bench builds the block with its defaults: seven channels and a 29-bit memory address. With these values the last channel window sits directly in front of the priority and flag registers. A start address with bits [31:29] set then shows the modulo-2^29 fetch together with the preserved high bits. A behavioural model keeps a queue of expected words for each channel and checks every handshake on every clock. It is run with the peripheral always ready, stalled and irregular. This covers overlapping channels, writes made while a channel is busy and stalled, zero block sizes and zero block counts.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int ZONE_AW  = 8;
    localparam int CH_IDX_W = 3;
    localparam int MAX_CH   = 7;
    localparam int FLAG_LSB = 24;

    localparam logic [3:0] WIN_ADDR  = 4'h0;
    localparam logic [3:0] WIN_BLK   = 4'h4;
    localparam logic [3:0] WIN_COUNT = 4'h6;
    localparam logic [3:0] WIN_CTRL  = 4'h8;

    localparam logic [ZONE_AW-1:0] ZONE_PRIO = 8'h70;
    localparam logic [ZONE_AW-1:0] ZONE_FLAG = 8'h74;

    localparam int CB_DIR  = 0;
    localparam int CB_CONT = 9;
    localparam int CB_LINK = 10;
    localparam int CB_RUN  = 24;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_WAIT = 2'd1,
        ENG_SEND = 2'd2
    } eng_state_e;

endpackage

// File: rtl/dmac_pick.sv
module dmac_pick #(
    parameter int N = 7
) (
    input  logic [N-1:0] req,
    output logic         any,
    output logic [2:0]   idx
);
    logic [N:0]   seen;
    logic [N-1:0] grant;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign grant[i]    = req[i] & ~seen[i];
        assign seen[i + 1] = seen[i] | req[i];
    end

    assign any = seen[N];

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx = 3'(i);
        end
    end
endmodule

// File: rtl/dmac_regs.sv
module dmac_regs
    import dmac_pkg::*;
#(
    parameter int NCH    = 7,
    parameter int MEM_AW = 29
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_wr,
    input  logic                          bus_half,
    input  logic [ZONE_AW-1:0]            bus_addr,
    input  logic [31:0]                   bus_wdata,
    output logic [31:0]                   bus_rdata,
    input  logic                          eng_adv,
    input  logic                          eng_blk,
    input  logic                          eng_retire,
    input  logic [CH_IDX_W-1:0]           eng_ch,
    output logic [NCH-1:0]                run,
    output logic [NCH-1:0][MEM_AW-1:0]    ch_addr,
    output logic [NCH-1:0][15:0]          ch_bsz,
    output logic [NCH-1:0][15:0]          ch_bcnt,
    output logic                          irq
);
    localparam logic [MEM_AW-1:0] STEP = MEM_AW'(4);

    typedef struct packed {
        logic [NCH-1:0][31:0] madr;
        logic [NCH-1:0][15:0] bsz;
        logic [NCH-1:0][15:0] bcnt;
        logic [NCH-1:0]       dir;
        logic [NCH-1:0]       cont;
        logic [NCH-1:0]       link;
        logic [NCH-1:0]       run;
        logic [31:0]          prio;
        logic [23:0]          flag_lo;
        logic [7:0]           flag_hi;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [3:0]          win_d;
    logic [3:0]          off_d;
    logic [CH_IDX_W-1:0] sel_d;
    logic                chan_hit_d;

    always_comb begin
        win_d      = bus_addr[7:4];
        off_d      = bus_addr[3:0];
        sel_d      = win_d[CH_IDX_W-1:0];
        chan_hit_d = (int'(win_d) < NCH);
    end

    always_comb begin
        regs_d = regs_q;

        if (bus_wr && chan_hit_d && !regs_q.run[sel_d]) begin
            if (!bus_half) begin
                case (off_d)
                    WIN_ADDR: regs_d.madr[sel_d] = bus_wdata;
                    WIN_BLK: begin
                        regs_d.bsz[sel_d]  = bus_wdata[15:0];
                        regs_d.bcnt[sel_d] = bus_wdata[31:16];
                    end
                    WIN_CTRL: begin
                        regs_d.dir[sel_d]  = bus_wdata[CB_DIR];
                        regs_d.cont[sel_d] = bus_wdata[CB_CONT];
                        regs_d.link[sel_d] = bus_wdata[CB_LINK];
                        regs_d.run[sel_d]  = bus_wdata[CB_RUN];
                    end
                    default: ;
                endcase
            end else if (off_d == WIN_COUNT) begin
                regs_d.bcnt[sel_d] = bus_wdata[15:0];
            end
        end

        if (bus_wr && !bus_half && bus_addr == ZONE_PRIO) begin
            regs_d.prio = bus_wdata;
        end

        if (bus_wr && !bus_half && bus_addr == ZONE_FLAG) begin
            regs_d.flag_lo = bus_wdata[23:0];
            regs_d.flag_hi = regs_q.flag_hi & ~bus_wdata[31:24];
        end

        if (eng_adv) begin
            regs_d.madr[eng_ch][MEM_AW-1:0] = regs_q.madr[eng_ch][MEM_AW-1:0] + STEP;
        end

        if (eng_blk) begin
            regs_d.bcnt[eng_ch] = regs_q.bcnt[eng_ch] - 16'd1;
        end

        if (eng_retire) begin
            regs_d.run[eng_ch]     = 1'b0;
            regs_d.flag_hi[eng_ch] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (chan_hit_d) begin
            case (off_d)
                WIN_ADDR: bus_rdata = regs_q.madr[sel_d];
                WIN_BLK:  bus_rdata = {regs_q.bcnt[sel_d], regs_q.bsz[sel_d]};
                WIN_CTRL: begin
                    bus_rdata[CB_DIR]  = regs_q.dir[sel_d];
                    bus_rdata[CB_CONT] = regs_q.cont[sel_d];
                    bus_rdata[CB_LINK] = regs_q.link[sel_d];
                    bus_rdata[CB_RUN]  = regs_q.run[sel_d];
                end
                default: ;
            endcase
        end else if (bus_addr == ZONE_PRIO) begin
            bus_rdata = regs_q.prio;
        end else if (bus_addr == ZONE_FLAG) begin
            bus_rdata = {regs_q.flag_hi, regs_q.flag_lo};
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_out
        assign ch_addr[c] = regs_q.madr[c][MEM_AW-1:0];
    end

    assign run     = regs_q.run;
    assign ch_bsz  = regs_q.bsz;
    assign ch_bcnt = regs_q.bcnt;
    assign irq     = |regs_q.flag_hi[NCH-1:0];
endmodule

// File: rtl/dmac_engine.sv
module dmac_engine
    import dmac_pkg::*;
#(
    parameter int NCH    = 7,
    parameter int MEM_AW = 29
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NCH-1:0]             run,
    input  logic [NCH-1:0][MEM_AW-1:0] ch_addr,
    input  logic [NCH-1:0][15:0]       ch_bsz,
    input  logic [NCH-1:0][15:0]       ch_bcnt,
    output logic                       mem_rd_en,
    output logic [MEM_AW-1:0]          mem_addr,
    input  logic [31:0]                mem_rdata,
    output logic                       st_valid,
    output logic [31:0]                st_data,
    output logic [CH_IDX_W-1:0]        st_chan,
    input  logic                       st_ready,
    output logic                       eng_adv,
    output logic                       eng_blk,
    output logic                       eng_retire,
    output logic [CH_IDX_W-1:0]        eng_ch
);
    typedef struct packed {
        eng_state_e          st;
        logic [CH_IDX_W-1:0] cur;
        logic [15:0]         left;
        logic [31:0]         data;
    } eng_t;

    eng_t eng_d, eng_q;

    logic                pick_any;
    logic [CH_IDX_W-1:0] pick_idx;

    dmac_pick #(.N(NCH)) u_pick (
        .req (run),
        .any (pick_any),
        .idx (pick_idx)
    );

    always_comb begin
        eng_d      = eng_q;
        mem_rd_en  = 1'b0;
        mem_addr   = '0;
        st_valid   = 1'b0;
        eng_adv    = 1'b0;
        eng_blk    = 1'b0;
        eng_retire = 1'b0;
        eng_ch     = eng_q.cur;

        case (eng_q.st)
            ENG_IDLE: begin
                if (pick_any) begin
                    eng_ch = pick_idx;
                    if (ch_bcnt[pick_idx] == 16'd0) begin
                        eng_retire = 1'b1;
                    end else if (ch_bsz[pick_idx] == 16'd0) begin
                        eng_blk    = 1'b1;
                        eng_retire = (ch_bcnt[pick_idx] == 16'd1);
                    end else begin
                        mem_rd_en  = 1'b1;
                        mem_addr   = ch_addr[pick_idx];
                        eng_adv    = 1'b1;
                        eng_d.cur  = pick_idx;
                        eng_d.left = ch_bsz[pick_idx];
                        eng_d.st   = ENG_WAIT;
                    end
                end
            end
            ENG_WAIT: begin
                eng_d.data = mem_rdata;
                eng_d.st   = ENG_SEND;
            end
            ENG_SEND: begin
                st_valid = 1'b1;
                if (st_ready) begin
                    eng_d.left = eng_q.left - 16'd1;
                    if (eng_q.left == 16'd1) begin
                        eng_blk    = 1'b1;
                        eng_retire = (ch_bcnt[eng_q.cur] == 16'd1);
                        eng_d.st   = ENG_IDLE;
                    end else begin
                        mem_rd_en = 1'b1;
                        mem_addr  = ch_addr[eng_q.cur];
                        eng_adv   = 1'b1;
                        eng_d.st  = ENG_WAIT;
                    end
                end
            end
            default: eng_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) eng_q <= '{st: ENG_IDLE, cur: '0, left: '0, data: '0};
        else        eng_q <= eng_d;
    end

    assign st_data = eng_q.data;
    assign st_chan = eng_q.cur;
endmodule

// File: rtl/dmac_top.sv
module dmac_top
    import dmac_pkg::*;
#(
    parameter int NCH    = 7,
    parameter int MEM_AW = 29
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_half,
    input  logic [7:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                mem_rd_en,
    output logic [MEM_AW-1:0]   mem_addr,
    input  logic [31:0]         mem_rdata,
    output logic                st_valid,
    output logic [31:0]         st_data,
    output logic [2:0]          st_chan,
    input  logic                st_ready,
    output logic                irq
);
    logic [NCH-1:0]             run_vec;
    logic [NCH-1:0][MEM_AW-1:0] addr_vec;
    logic [NCH-1:0][15:0]       bsz_vec;
    logic [NCH-1:0][15:0]       bcnt_vec;
    logic                       eng_adv;
    logic                       eng_blk;
    logic                       eng_retire;
    logic [CH_IDX_W-1:0]        eng_ch;

    dmac_regs #(.NCH(NCH), .MEM_AW(MEM_AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_half   (bus_half),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .eng_adv    (eng_adv),
        .eng_blk    (eng_blk),
        .eng_retire (eng_retire),
        .eng_ch     (eng_ch),
        .run        (run_vec),
        .ch_addr    (addr_vec),
        .ch_bsz     (bsz_vec),
        .ch_bcnt    (bcnt_vec),
        .irq        (irq)
    );

    dmac_engine #(.NCH(NCH), .MEM_AW(MEM_AW)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run_vec),
        .ch_addr    (addr_vec),
        .ch_bsz     (bsz_vec),
        .ch_bcnt    (bcnt_vec),
        .mem_rd_en  (mem_rd_en),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .st_valid   (st_valid),
        .st_data    (st_data),
        .st_chan    (st_chan),
        .st_ready   (st_ready),
        .eng_adv    (eng_adv),
        .eng_blk    (eng_blk),
        .eng_retire (eng_retire),
        .eng_ch     (eng_ch)
    );
endmodule

// File: rtl/dmac_chk.sv
module dmac_chk #(
    parameter int NCH = 7
) (
    input logic           clk,
    input logic           rst_n,
    input logic           mem_rd_en,
    input logic           st_valid,
    input logic           st_ready,
    input logic [31:0]    st_data,
    input logic [2:0]     st_chan,
    input logic           irq,
    input logic           retire,
    input logic [2:0]     ev_ch,
    input logic [NCH-1:0] busy
);
    // R5
    hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && !st_ready |=> st_valid && $stable(st_data) && $stable(st_chan));

    // R5
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en && !st_valid);

    // R5
    no_read_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && !st_ready |-> !mem_rd_en);

    // R4
    owner_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> busy[st_chan]);

    // R6
    retire_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> !busy[$past(ev_ch)]);

    // R12
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(retire));
endmodule

bind dmac_top dmac_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rd_en (mem_rd_en),
    .st_valid  (st_valid),
    .st_ready  (st_ready),
    .st_data   (st_data),
    .st_chan   (st_chan),
    .irq       (irq),
    .retire    (eng_retire),
    .ev_ch     (eng_ch),
    .busy      (run_vec)
);

// File: tb/dmac_top_tb.sv
module dmac_top_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_half = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mem_rd_en;
    logic [28:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        st_valid;
    logic [31:0] st_data;
    logic [2:0]  st_chan;
    logic        st_ready = 1'b1;
    logic        irq;

    int nchecks = 0;
    int nfail   = 0;
    int ready_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [31:0] expq [7][$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    dmac_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_half(bus_half),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .st_valid(st_valid), .st_data(st_data), .st_chan(st_chan),
        .st_ready(st_ready), .irq(irq)
    );

    function automatic logic [31:0] memf(input logic [28:0] a);
        return {a, 3'b101} ^ 32'h9E37_4C11;
    endfunction

    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= memf(mem_addr);
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        nchecks++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // stream reference: every clock, compare each accepted word against the model queue
    always @(negedge clk) begin
        case (ready_mode)
            0: st_ready = 1'b1;
            1: st_ready = 1'b0;
            default: st_ready = lfsr[0] | lfsr[3];
        endcase
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        #1;
        if (rst_n && st_valid && st_ready) begin
            if (expq[st_chan].size() == 0) begin
                check(32'd1, 32'd0, "R4 word with no pending expectation");
            end else begin
                check(st_data, expq[st_chan].pop_front(), "R4 streamed word");
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_half = 1'b0; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wr_half(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_half = 1'b1; bus_addr = a; bus_wdata = {16'h0, d};
        @(negedge clk);
        bus_wr = 1'b0; bus_half = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(bus_rdata, exp, tag);
    endtask

    task automatic start_xfer(input int ch, input logic [31:0] madr,
                              input logic [15:0] bs, input logic [15:0] cnt,
                              input logic [31:0] ctl);
        logic [28:0] a;
        a = madr[28:0];
        for (int k = 0; k < int'(bs) * int'(cnt); k++) begin
            expq[ch].push_back(memf(a));
            a = a + 29'd4;
        end
        wr(8'(ch * 16), madr);
        wr(8'(ch * 16 + 4), {cnt, bs});
        wr(8'(ch * 16 + 8), ctl);
    endtask

    task automatic wait_done(input int ch);
        bit done;
        done = 1'b0;
        for (int i = 0; i < 4000 && !done; i++) begin
            @(negedge clk);
            bus_addr = 8'(ch * 16 + 8);
            #1;
            if (!bus_rdata[24]) done = 1'b1;
        end
        check({31'd0, done}, 32'd1, "R6 run bit clears at end of transfer");
    endtask

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        check(32'd1, 32'd0, "watchdog expired");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R13: reset state
        rd_chk(8'h00, 32'h0, "R13 ch0 address after reset");
        rd_chk(8'h64, 32'h0, "R13 ch6 block word after reset");
        rd_chk(8'h38, 32'h0, "R13 ch3 control after reset");
        rd_chk(8'h70, 32'h0, "R13 priority after reset");
        rd_chk(8'h74, 32'h0, "R13 flags after reset");
        check({29'd0, irq, st_valid, mem_rd_en}, 32'h0, "R13 outputs idle after reset");

        // R1 R3: window layout and control masking on ch3
        wr(8'h30, 32'h89AB_CDEF);
        rd_chk(8'h30, 32'h89AB_CDEF, "R1 ch3 address readback");
        wr(8'h34, 32'h0007_0002);
        rd_chk(8'h34, 32'h0007_0002, "R1 ch3 block word readback");
        wr(8'h38, 32'hFEFF_FFFF);
        rd_chk(8'h38, 32'h0000_0601, "R3 only stored control bits read back");

        // R2: count half write, and full write at 0x6 ignored
        wr_half(8'h36, 16'h0005);
        rd_chk(8'h34, 32'h0005_0002, "R2 half write replaces count only");
        wr(8'h36, 32'h1111_2222);
        rd_chk(8'h34, 32'h0005_0002, "R2 full write at count offset ignored");

        // R9: priority and low flag bits
        wr(8'h70, 32'hCAFE_F00D);
        rd_chk(8'h70, 32'hCAFE_F00D, "R9 priority readback");
        wr(8'h74, 32'h1234_5678);
        rd_chk(8'h74, 32'h0034_5678, "R8 low flag bits stored, high only cleared");

        // R10: unmapped offsets
        wr(8'h3C, 32'hFFFF_FFFF);
        rd_chk(8'h3C, 32'h0, "R10 window offset 0xC reads zero");
        rd_chk(8'h36, 32'h0, "R10 offset 0x6 reads zero");
        rd_chk(8'h78, 32'h0, "R10 offset 0x78 reads zero");
        rd_chk(8'hF0, 32'h0, "R10 offset 0xF0 reads zero");

        // R4 R6 R12: ch1, 2 blocks of 3 words, ready always high
        ready_mode = 0;
        start_xfer(1, 32'h0000_1000, 16'd3, 16'd2, 32'h0100_0201);
        wait_done(1);
        check(32'(expq[1].size()), 32'd0, "R4 ch1 all words delivered");
        rd_chk(8'h18, 32'h0000_0201, "R6 ch1 control after end");
        rd_chk(8'h14, 32'h0000_0003, "R6 ch1 count reached zero");
        rd_chk(8'h10, 32'h0000_1018, "R6 ch1 address advanced by 4 per word");
        rd_chk(8'h74, 32'h0234_5678, "R6 flag bit 25 set");
        check({31'd0, irq}, 32'd1, "R12 irq high with flag set");

        // R4 R6: address modulo 2^29 on ch6, irregular ready
        ready_mode = 2;
        start_xfer(6, 32'hE000_0010, 16'd2, 16'd1, 32'h0100_0000);
        wait_done(6);
        check(32'(expq[6].size()), 32'd0, "R4 ch6 words from wrapped address");
        rd_chk(8'h60, 32'hE000_0018, "R6 ch6 high address bits kept");

        // R11: writes while busy are ignored (stream stalled)
        ready_mode = 1;
        start_xfer(0, 32'h0000_0200, 16'd4, 16'd3, 32'h0100_0000);
        repeat (5) @(negedge clk);
        wr(8'h00, 32'hDEAD_0000);
        wr(8'h04, 32'h0001_0001);
        wr_half(8'h06, 16'h0009);
        wr(8'h08, 32'h0000_0000);
        rd_chk(8'h00, 32'h0000_0204, "R11 busy address write ignored");
        rd_chk(8'h04, 32'h0003_0004, "R11 busy block writes ignored");
        rd_chk(8'h08, 32'h0100_0000, "R11 busy control write ignored");
        ready_mode = 2;
        wait_done(0);
        check(32'(expq[0].size()), 32'd0, "R11 ch0 transfer intact after ignored writes");

        // R8 R12: write-one-to-clear flags
        rd_chk(8'h74, 32'h4334_5678, "R8 flags 24 25 30 set");
        wr(8'h74, 32'h02AB_CDEF);
        rd_chk(8'h74, 32'h41AB_CDEF, "R8 only written-one flag cleared");
        check({31'd0, irq}, 32'd1, "R12 irq stays with flags left");
        wr(8'h74, 32'hFF00_0000);
        rd_chk(8'h74, 32'h0000_0000, "R8 all flags cleared");
        @(negedge clk);
        check({31'd0, irq}, 32'd0, "R12 irq low with no flags");

        // R7: zero count and zero block size
        start_xfer(2, 32'h0000_3000, 16'd5, 16'd0, 32'h0100_0000);
        wait_done(2);
        rd_chk(8'h74, 32'h0400_0000, "R7 zero count sets flag 26 with no words");
        rd_chk(8'h24, 32'h0000_0005, "R7 zero count leaves block word");
        start_xfer(4, 32'h0000_5000, 16'd0, 16'd3, 32'h0100_0000);
        wait_done(4);
        rd_chk(8'h44, 32'h0000_0000, "R7 zero size uses up all blocks");
        rd_chk(8'h40, 32'h0000_5000, "R7 zero size moves no address");
        rd_chk(8'h74, 32'h1400_0000, "R7 flag 28 set");
        wr(8'h74, 32'hFF00_0000);

        // R4: two channels overlapping
        start_xfer(5, 32'h0000_4000, 16'd3, 16'd2, 32'h0100_0000);
        start_xfer(3, 32'h0000_8000, 16'd2, 16'd3, 32'h0100_0000);
        wait_done(5);
        wait_done(3);
        check(32'(expq[5].size()), 32'd0, "R4 ch5 words delivered");
        check(32'(expq[3].size()), 32'd0, "R4 ch3 words delivered");
        rd_chk(8'h74, 32'h2800_0000, "R6 flags 27 and 29 set");

        repeat (5) @(negedge clk);
        report();
    end
endmodule